// File: doc/BRIEF.md
# Serial Port with Powerdown Handling

This block is a synchronous serial transmitter and receiver for one processor. The processor side writes a transmit data register and reads a receive data register; the line side shifts words out on `ser_dout` and in on `ser_din`, most significant bit first, with a word length chosen at run time from 4 to 16 bits. The bit clock is either divided down from the system clock or taken from an external serial clock input. The transmit framing pulse and the receive framing pulse can each be generated inside the block or taken from an input.

A powerdown input cuts the processor off from the port while the line-side shifting keeps working wherever its clock still runs. With an external bit clock and external framing, the frozen transmit word is sent again on every frame and each received word overwrites the last. An internally framed receiver keeps framing from the external clock. An internally framed transmitter finishes the word in flight and then stays silent. A divided-down clock simply stops. Each direction has one latched event flag; flags raised during powerdown are held and presented once powerdown ends.

States: both shift engines have `SH_IDLE` and `SH_BUSY`. Transitions: `SH_IDLE -> SH_BUSY` on a bit tick with a framing pulse; transmitter `SH_BUSY -> SH_BUSY` (reload) on the final tick when a new framing pulse arrives; `SH_BUSY -> SH_IDLE` on the final tick otherwise.

Top module: `serial_port_pd`

## Requirements
- R1: A transmitted word has `len_m1+1` bits, most significant first. The word's top bit appears on `ser_dout` right after the bit tick that starts the frame, and each later tick presents the next bit.
- R2: With internal transmit framing, a frame starts only if the transmit register was written since the last frame began. `txfs_out` is high for one cycle after the starting tick.
- R3: With external transmit framing, every tick with `txfs_in` high that finds the transmitter idle or on its final tick starts a frame from the current transmit register, even if it was not rewritten.
- R4: While `pwrdn` is high, `tx_wr` has no effect, so every frame sent carries the word held before powerdown.
- R5: The receiver samples `ser_din` on the framing tick and on the `len_m1` ticks after it. It then writes the word, right-aligned with zeroed upper bits, to `rx_rdata`, replacing any earlier word. This happens in powerdown too.
- R6: With internal receive framing, `rxfs_out` pulses for one cycle every `len_m1+1` bit ticks, and this continues during powerdown when the bit clock is external.
- R7: With internal transmit framing, a word in flight when powerdown starts is completed, and no new frame starts while `pwrdn` is high, even with a pending write.
- R8: With the internal bit clock selected, `sclk_out` toggles with period `DIV` cycles. During powerdown it stops, and `ser_dout` stays constant.
- R9: `tx_irq` latches when a transmit frame starts and `rx_irq` when a received word is stored. Both read 0 while `pwrdn` is high. `tx_ack` and `rx_ack` clear them, except that acknowledges during powerdown are ignored.
- R10: After reset, `ser_dout`, `txfs_out`, `rxfs_out`, `tx_irq`, `rx_irq` and `rx_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| pwrdn | input | 1 | Powerdown request |
| clk_int_sel | input | 1 | 1: bit clock divided from `clk`; 0: from `sclk_in` |
| txfs_int_sel | input | 1 | 1: transmit framing generated inside |
| rxfs_int_sel | input | 1 | 1: receive framing generated inside |
| len_m1 | input | 4 | Word length minus one (3 to 15) |
| sclk_in | input | 1 | External bit clock, synchronous to `clk`; rising edge is a tick |
| sclk_out | output | 1 | Internal bit clock |
| txfs_in | input | 1 | External transmit framing, sampled on ticks |
| txfs_out | output | 1 | Internal transmit framing pulse |
| rxfs_in | input | 1 | External receive framing, sampled on ticks |
| rxfs_out | output | 1 | Internal receive framing pulse |
| ser_dout | output | 1 | Serial data out |
| ser_din | input | 1 | Serial data in, sampled on ticks |
| tx_wr | input | 1 | Transmit register write strobe |
| tx_wdata | input | 16 | Transmit write data |
| rx_rdata | output | 16 | Receive register |
| tx_irq | output | 1 | Transmit event flag |
| rx_irq | output | 1 | Receive event flag |
| tx_ack | input | 1 | Clears `tx_irq` |
| rx_ack | input | 1 | Clears `rx_irq` |

## Verification
The assertions assume that `sclk_in` is already synchronous to `clk` and stays high or low for at least one full cycle, so that two bit ticks are never adjacent. They also assume the mode selects and `len_m1` change only while no word is in flight. The stimulus drives every external tick as one high cycle followed by one low cycle, with framing and data held steady for the high cycle. Modes and lengths are changed only between scenarios, after the previous word has finished.

// File: rtl/sp_pkg.sv
package sp_pkg;
    typedef enum logic {
        SH_IDLE,
        SH_BUSY
    } sh_state_t;
endpackage

// File: rtl/sp_bitclk.sv
module sp_bitclk #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwrdn,
    input  logic clk_int_sel,
    input  logic sclk_in,
    output logic tick,
    output logic sclk_out
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF = CW'(DIV / 2);

    logic [CW-1:0] div_q;
    logic          ext_q;
    logic          run;

    assign run = clk_int_sel && !pwrdn;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
            ext_q <= 1'b0;
        end else begin
            ext_q <= sclk_in;
            if (run)
                div_q <= (div_q == LAST) ? '0 : div_q + CW'(1);
        end
    end

    // internal ticks stop in powerdown; external edge detect does not
    assign tick     = clk_int_sel ? (run && div_q == LAST) : (sclk_in && !ext_q);
    assign sclk_out = clk_int_sel && (div_q >= HALF);
endmodule

// File: rtl/sp_tx.sv
module sp_tx
    import sp_pkg::*;
#(
    parameter int W  = 16,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          pwrdn,
    input  logic          fs_int,
    input  logic          fs_in,
    input  logic [LW-1:0] len_m1,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    output logic          dout,
    output logic          fs_out,
    output logic          load_evt,
    output logic [W-1:0]  hold_q
);
    sh_state_t     st_q, st_d;
    logic [LW-1:0] cnt_q;
    logic [W-1:0]  sh_q;
    logic          full_q;
    logic          fso_q;
    logic          slot_free;
    logic          fs_go;
    logic [LW-1:0] sh_amt;

    assign slot_free = (st_q == SH_IDLE) || (cnt_q == '0);
    assign fs_go     = tick && slot_free && (fs_int ? (full_q && !pwrdn) : fs_in);
    assign sh_amt    = LW'(W - 1) - len_m1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SH_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SH_IDLE: st_d = fs_go ? SH_BUSY : SH_IDLE;
            SH_BUSY: if (tick && cnt_q == '0) st_d = fs_go ? SH_BUSY : SH_IDLE;
        endcase
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            full_q <= 1'b0;
            hold_q <= '0;
            fso_q  <= 1'b0;
        end else begin
            fso_q <= fs_go && fs_int;
            if (fs_go) begin
                sh_q  <= hold_q << sh_amt;
                cnt_q <= len_m1;
            end else if (tick && st_q == SH_BUSY && cnt_q != '0) begin
                sh_q  <= sh_q << 1;
                cnt_q <= cnt_q - LW'(1);
            end
            if (fs_go) full_q <= 1'b0;
            if (wr && !pwrdn) begin
                hold_q <= wdata;
                full_q <= 1'b1;
            end
        end
    end

    assign dout     = sh_q[W-1];
    assign fs_out   = fso_q;
    assign load_evt = fs_go;
endmodule

// File: rtl/sp_rx.sv
module sp_rx
    import sp_pkg::*;
#(
    parameter int W  = 16,
    parameter int LW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          fs_int,
    input  logic          fs_in,
    input  logic [LW-1:0] len_m1,
    input  logic          din,
    output logic [W-1:0]  word_q,
    output logic          done,
    output logic          fs_out
);
    sh_state_t     st_q, st_d;
    logic [LW-1:0] cnt_q;
    logic [LW-1:0] fc_q;
    logic [W-1:0]  sh_q;
    logic          done_q;
    logic          fso_q;
    logic          fs_now;
    logic          start;

    assign fs_now = fs_int ? (fc_q == '0) : fs_in;
    assign start  = tick && st_q == SH_IDLE && fs_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SH_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            SH_IDLE: st_d = start ? SH_BUSY : SH_IDLE;
            SH_BUSY: if (tick && cnt_q == '0) st_d = SH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            fc_q   <= '0;
            sh_q   <= '0;
            word_q <= '0;
            done_q <= 1'b0;
            fso_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            fso_q  <= tick && fs_int && fc_q == '0;
            if (tick)
                fc_q <= (fc_q >= len_m1) ? '0 : fc_q + LW'(1);
            if (start) begin
                sh_q  <= W'(din);
                cnt_q <= len_m1 - LW'(1);
            end else if (tick && st_q == SH_BUSY) begin
                sh_q <= {sh_q[W-2:0], din};
                if (cnt_q == '0) begin
                    word_q <= {sh_q[W-2:0], din};
                    done_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - LW'(1);
                end
            end
        end
    end

    assign done   = done_q;
    assign fs_out = fso_q;
endmodule

// File: rtl/serial_port_pd.sv
module serial_port_pd #(
    parameter int W   = 16,
    parameter int DIV = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwrdn,
    input  logic                 clk_int_sel,
    input  logic                 txfs_int_sel,
    input  logic                 rxfs_int_sel,
    input  logic [$clog2(W)-1:0] len_m1,
    input  logic                 sclk_in,
    output logic                 sclk_out,
    input  logic                 txfs_in,
    output logic                 txfs_out,
    input  logic                 rxfs_in,
    output logic                 rxfs_out,
    output logic                 ser_dout,
    input  logic                 ser_din,
    input  logic                 tx_wr,
    input  logic [W-1:0]         tx_wdata,
    output logic [W-1:0]         rx_rdata,
    output logic                 tx_irq,
    output logic                 rx_irq,
    input  logic                 tx_ack,
    input  logic                 rx_ack
);
    localparam int LW = $clog2(W);

    logic         tick;
    logic         tx_load;
    logic         rx_done;
    logic [W-1:0] tx_q;
    logic         tx_flag_q;
    logic         rx_flag_q;

    sp_bitclk #(.DIV(DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .pwrdn(pwrdn), .clk_int_sel(clk_int_sel),
        .sclk_in(sclk_in), .tick(tick), .sclk_out(sclk_out)
    );

    sp_tx #(.W(W), .LW(LW)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .pwrdn(pwrdn),
        .fs_int(txfs_int_sel), .fs_in(txfs_in), .len_m1(len_m1),
        .wr(tx_wr), .wdata(tx_wdata), .dout(ser_dout), .fs_out(txfs_out),
        .load_evt(tx_load), .hold_q(tx_q)
    );

    sp_rx #(.W(W), .LW(LW)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .fs_int(rxfs_int_sel),
        .fs_in(rxfs_in), .len_m1(len_m1), .din(ser_din),
        .word_q(rx_rdata), .done(rx_done), .fs_out(rxfs_out)
    );

    // event flags: set wins over clear, clears blocked in powerdown
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_flag_q <= 1'b0;
            rx_flag_q <= 1'b0;
        end else begin
            if (tx_load)                tx_flag_q <= 1'b1;
            else if (tx_ack && !pwrdn)  tx_flag_q <= 1'b0;
            if (rx_done)                rx_flag_q <= 1'b1;
            else if (rx_ack && !pwrdn)  rx_flag_q <= 1'b0;
        end
    end

    assign tx_irq = tx_flag_q && !pwrdn;
    assign rx_irq = rx_flag_q && !pwrdn;
endmodule

// File: rtl/serial_port_pd_chk.sv
module serial_port_pd_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pwrdn,
    input logic         clk_int_sel,
    input logic         txfs_int_sel,
    input logic         sclk_out,
    input logic         ser_dout,
    input logic         txfs_out,
    input logic         rxfs_out,
    input logic [W-1:0] tx_q,
    input logic         tx_flag
);
    // R8
    clk_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_int_sel && $past(clk_int_sel) && pwrdn && $past(pwrdn))
            |-> ($stable(sclk_out) && $stable(ser_dout)));

    // R7
    no_txfs_in_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txfs_int_sel && $past(txfs_int_sel) && $past(pwrdn)) |-> !txfs_out);

    // R4
    tx_hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pwrdn) |-> $stable(tx_q));

    // R9
    flag_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwrdn) && $past(tx_flag)) |-> tx_flag);

    // R6
    rxfs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rxfs_out |=> !rxfs_out);
endmodule

bind serial_port_pd serial_port_pd_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwrdn(pwrdn), .clk_int_sel(clk_int_sel),
    .txfs_int_sel(txfs_int_sel), .sclk_out(sclk_out), .ser_dout(ser_dout),
    .txfs_out(txfs_out), .rxfs_out(rxfs_out), .tx_q(tx_q), .tx_flag(tx_flag_q)
);

// File: tb/serial_port_pd_test.sv
`timescale 1ns/1ps
module serial_port_pd_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        pwrdn = 0, clk_int_sel = 0, txfs_int_sel = 0, rxfs_int_sel = 0;
    logic [3:0]  len_m1 = 4'd7;
    logic        sclk_in = 0, txfs_in = 0, rxfs_in = 0, ser_din = 0;
    logic        tx_wr = 0, tx_ack = 0, rx_ack = 0;
    logic [15:0] tx_wdata = 0;
    logic        sclk_out, txfs_out, rxfs_out, ser_dout, tx_irq, rx_irq;
    logic [15:0] rx_rdata;
    int          n_chk = 0, n_err = 0;

    always #4 clk = ~clk;

    serial_port_pd uut (
        .clk(clk), .rst_n(rst_n), .pwrdn(pwrdn), .clk_int_sel(clk_int_sel),
        .txfs_int_sel(txfs_int_sel), .rxfs_int_sel(rxfs_int_sel), .len_m1(len_m1),
        .sclk_in(sclk_in), .sclk_out(sclk_out), .txfs_in(txfs_in), .txfs_out(txfs_out),
        .rxfs_in(rxfs_in), .rxfs_out(rxfs_out), .ser_dout(ser_dout), .ser_din(ser_din),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .rx_rdata(rx_rdata), .tx_irq(tx_irq),
        .rx_irq(rx_irq), .tx_ack(tx_ack), .rx_ack(rx_ack)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one external bit tick: high cycle then low cycle
    task automatic xtick(input logic tf, input logic rf, input logic d,
                         output logic o_d, output logic o_tf, output logic o_rf);
        @(negedge clk);
        sclk_in = 1; txfs_in = tf; rxfs_in = rf; ser_din = d;
        @(negedge clk);
        o_d = ser_dout; o_tf = txfs_out; o_rf = rxfs_out;
        sclk_in = 0; txfs_in = 0; rxfs_in = 0;
    endtask

    task automatic write_tx(input logic [15:0] d);
        @(negedge clk); tx_wr = 1; tx_wdata = d;
        @(negedge clk); tx_wr = 0;
    endtask

    task automatic ack_both();
        @(negedge clk); tx_ack = 1; rx_ack = 1;
        @(negedge clk); tx_ack = 0; rx_ack = 0;
    endtask

    task automatic t_reset();
        check("R10 dout", 16'(ser_dout), 0);
        check("R10 fs", {14'd0, txfs_out, rxfs_out}, 0);
        check("R10 irq", {14'd0, tx_irq, rx_irq}, 0);
        check("R10 rx_rdata", rx_rdata, 0);
    endtask

    task automatic t_int_frame();
        logic [15:0] w; logic od, otf, orf; int seen;
        clk_int_sel = 0; txfs_int_sel = 1; rxfs_int_sel = 0; len_m1 = 7;
        write_tx(16'h00A5);
        w = 0;
        for (int i = 0; i < 8; i++) begin
            xtick(0, 0, 0, od, otf, orf);
            if (i == 0) check("R2 txfs_out on start", 16'(otf), 1);
            w = {w[14:0], od};
        end
        check("R1 8-bit word msb first", w, 16'h00A5);
        check("R9 tx_irq set", 16'(tx_irq), 1);
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            xtick(0, 0, 0, od, otf, orf);
            seen += int'(otf);
        end
        check("R2 no frame without write", 16'(seen), 0);
        ack_both();
        check("R9 tx_irq cleared", 16'(tx_irq), 0);
    endtask

    task automatic t_rx_min();
        logic od, otf, orf;
        txfs_int_sel = 0; len_m1 = 3;
        xtick(0, 1, 1, od, otf, orf);
        xtick(0, 0, 0, od, otf, orf);
        xtick(0, 0, 1, od, otf, orf);
        xtick(0, 0, 1, od, otf, orf);
        @(negedge clk);
        check("R5 4-bit word", rx_rdata, 16'h000B);
        check("R9 rx_irq set", 16'(rx_irq), 1);
        ack_both();
    endtask

    task automatic t_ext_pd();
        logic [15:0] w, d; logic od, otf, orf;
        clk_int_sel = 0; txfs_int_sel = 0; rxfs_int_sel = 0; len_m1 = 15;
        write_tx(16'hC3A5);
        ack_both();
        @(negedge clk); pwrdn = 1;
        write_tx(16'h1234);
        for (int f = 0; f < 2; f++) begin
            d = (f == 0) ? 16'h0F0F : 16'h7E81;
            w = 0;
            for (int i = 0; i < 16; i++) begin
                xtick(i == 0, i == 0, d[15-i], od, otf, orf);
                w = {w[14:0], od};
            end
            check(f == 0 ? "R3 external frame 1" : "R4 resent word frame 2", w, 16'hC3A5);
        end
        @(negedge clk);
        check("R9 irqs masked in pd", {14'd0, tx_irq, rx_irq}, 0);
        tx_ack = 1; rx_ack = 1;
        @(negedge clk); tx_ack = 0; rx_ack = 0; pwrdn = 0;
        @(negedge clk);
        check("R5 overwritten word", rx_rdata, 16'h7E81);
        check("R9 flags held over pd", {14'd0, tx_irq, rx_irq}, 16'h0003);
        ack_both();
    endtask

    task automatic t_int_fs_pd();
        logic [15:0] w; logic od, otf, orf; int seen;
        clk_int_sel = 0; txfs_int_sel = 1; rxfs_int_sel = 0; len_m1 = 7;
        write_tx(16'h003C);
        w = 0;
        xtick(0, 0, 0, od, otf, orf); w = {w[14:0], od};
        write_tx(16'h0099);
        for (int i = 1; i < 8; i++) begin
            if (i == 3) begin @(negedge clk); pwrdn = 1; end
            xtick(0, 0, 0, od, otf, orf);
            w = {w[14:0], od};
        end
        check("R7 word in flight completes", w, 16'h003C);
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            xtick(0, 0, 0, od, otf, orf);
            seen += int'(otf);
        end
        check("R7 no frame in pd", 16'(seen), 0);
        @(negedge clk); pwrdn = 0;
        w = 0;
        for (int i = 0; i < 8; i++) begin
            xtick(0, 0, 0, od, otf, orf);
            if (i == 0) check("R2 pending write framed after exit", 16'(otf), 1);
            w = {w[14:0], od};
        end
        check("R1 second word", w, 16'h0099);
        ack_both();
    endtask

    task automatic t_rxfs_pd();
        logic od, otf, orf; int seen;
        clk_int_sel = 0; txfs_int_sel = 0; rxfs_int_sel = 1; len_m1 = 4;
        @(negedge clk); pwrdn = 1;
        for (int i = 0; i < 5; i++) xtick(0, 0, 0, od, otf, orf);
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            xtick(0, 0, 0, od, otf, orf);
            seen += int'(orf);
        end
        check("R6 rxfs pulses in pd", 16'(seen), 2);
        @(negedge clk); pwrdn = 0; rxfs_int_sel = 0;
        ack_both();
    endtask

    task automatic t_int_clk();
        int edges; logic prev, s0, d0, bad;
        txfs_int_sel = 0; clk_int_sel = 1;
        @(negedge clk); prev = sclk_out; edges = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sclk_out && !prev) edges++;
            prev = sclk_out;
        end
        check("R8 clock runs", 16'(edges), 10);
        pwrdn = 1;
        @(negedge clk); @(negedge clk);
        s0 = sclk_out; d0 = ser_dout; bad = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sclk_out !== s0 || ser_dout !== d0) bad = 1;
        end
        check("R8 clock frozen in pd", 16'(bad), 0);
        pwrdn = 0; clk_int_sel = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_int_frame();
        t_rx_min();
        t_ext_pd();
        t_int_fs_pd();
        t_rxfs_pd();
        t_int_clk();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule